// File: doc/BRIEF.md
# Speculative Direct-Mapped Load Path

This block is the read side of a small level-1 data cache that hands load data to the consumer before it knows whether that data is correct. The block adds a base operand and an offset operand to form a 32-bit virtual address. Its low bits select a word in a direct-mapped data array. That word is shifted and zero-extended to the requested access size and presented one cycle after the request is accepted. No tag is read for this first return.

One cycle later the block reads the line's tag and valid bit, compares them with the upper address bits, and reports a hit or a miss. On a miss it stops taking new loads and requests the whole line from a memory-side port as eight 32-bit beats. It writes the beats into the data array and then marks the line valid under its new tag. It then pulses a restart output so the surrounding pipeline can replay the load, which will now hit.

The default geometry is 4 KB in 128 lines of 32 bytes. An address is split into a 5-bit byte offset (bits 4:0), a 7-bit line index (bits 11:5) and a 20-bit tag (bits 31:12).

Top module: `spec_load_path`

## Requirements
- R1: The access address is `reqBase + reqOffset` modulo 2^32. The index, tag, word and byte fields are all taken from this sum.
- R2: A load is accepted in a cycle where `reqValid` and `reqReady` are both high. In the next cycle `loadValid` is high for exactly one cycle, and `loadData` carries the array word at that address, whether or not the line later hits.
- R3: `reqSize` code 0 selects a byte, 1 a halfword, and 2 or 3 a full word. The word is shifted right by 8×address[1:0] bits, the low 8, 16 or 32 bits are kept, and the upper bits are zero.
- R4: Two cycles after acceptance, `checkValid` is high for one cycle. `checkHit` is 1 exactly when the indexed line is valid and its stored tag equals address[31:12].
- R5: After reset every line is invalid, so the first load to any line reports a miss.
- R6: On a miss, `memReqValid` rises in the same cycle as the miss verdict, with `memReqAddr` = {address[31:5], 5'b0}. It holds steady until `memReqReady` is seen and drops in the following cycle.
- R7: After the line request is taken, `memRspReady` stays high until eight response beats have been accepted. Beat k is stored as word k of the line (byte offset 4k). After the eighth beat the line is valid under the missing tag.
- R8: `restart` is high for exactly one cycle, the cycle after the eighth beat is accepted.
- R9: `reqReady` is low in the cycle after a missing load is accepted and stays low through the restart cycle. It is high again in the cycle that follows.
- R10: During and right after reset, `reqReady` is high and `loadValid`, `checkValid`, `memReqValid` and `restart` are low.
- R11: A refill of one line replaces the tag at its index only. A load whose tag differs from the one now held at the same index misses, and lines at other indices are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Block can accept a load |
| reqBase | input | 32 | Base operand of the address |
| reqOffset | input | 32 | Offset operand of the address |
| reqSize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| loadValid | output | 1 | Speculative load data present |
| loadData | output | 32 | Aligned, zero-extended load data |
| checkValid | output | 1 | Tag verdict present |
| checkHit | output | 1 | Verdict: 1 hit, 0 miss |
| memReqValid | output | 1 | Line fetch request |
| memReqReady | input | 1 | Memory takes the line request |
| memReqAddr | output | 32 | Line-aligned fetch address |
| memRspValid | input | 1 | Refill beat present |
| memRspReady | output | 1 | Block accepts refill beats |
| memRspData | input | 32 | Refill beat data |
| restart | output | 1 | One-cycle replay pulse after a refill |

## Verification
Loads are generated from random base and offset pairs whose sums fall on a few indices and two tags. This mixes cold misses, hits, and conflict evictions at the same index, and it catches an adder or field-split error because the wrong line would be touched. Directed cases cover each of the following:
- a sum that wraps past 2^32;
- every size code at every byte position, which separates the shift amount from the size mask;
- a sweep of all eight words after a refill, which shows the beat order;
- two back-to-back hits, which show the data and verdict stages stay aligned.

Random gaps on both memory handshakes show whether the refill waits on the valid/ready signals rather than on fixed timing.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2,
    ST_DONE = 2'd3
  } slp_state_e;

  typedef struct packed {
    logic accept;
    logic captureMiss;
    logic fillWrite;
    logic tagWrite;
  } slp_ctrl_t;

endpackage

// File: rtl/slp_aligner.sv
module slp_aligner #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         wordIn,
  input  logic [$clog2(DATA_W/8)-1:0] byteSel,
  input  logic [1:0]                sizeCode,
  output logic [DATA_W-1:0]         dataOut
);
  localparam int BSEL_W = $clog2(DATA_W/8);

  logic [DATA_W-1:0]   shifted;
  logic [BSEL_W+2:0]   shiftAmt;

  assign shiftAmt = {byteSel, 3'b000};
  assign shifted  = wordIn >> shiftAmt;

  always_comb begin
    case (sizeCode)
      2'd0:    dataOut = {{(DATA_W-8){1'b0}}, shifted[7:0]};
      2'd1:    dataOut = {{(DATA_W-16){1'b0}}, shifted[15:0]};
      default: dataOut = shifted;
    endcase
  end
endmodule

// File: rtl/slp_datapath.sv
module slp_datapath
  import slp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 128,
  localparam int BEATS     = LINE_BYTES / (DATA_W/8),
  localparam int BEAT_W    = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  slp_ctrl_t         ctrl,
  input  logic [BEAT_W-1:0] fillBeat,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] fillData,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData,
  output logic              checkValid,
  output logic              checkHit,
  output logic              s1Miss,
  output logic [ADDR_W-1:0] missLineAddr
);
  localparam int BSEL_W = $clog2(DATA_W/8);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WORDS  = NUM_LINES * BEATS;

  // address generation and field split
  logic [ADDR_W-1:0] vAddr;
  logic [IDX_W-1:0]  aIdx;
  logic [TAG_W-1:0]  aTag;
  logic [BEAT_W-1:0] aWord;
  logic [BSEL_W-1:0] aByte;

  assign vAddr = reqBase + reqOffset;
  assign aByte = vAddr[BSEL_W-1:0];
  assign aWord = vAddr[OFF_W-1:BSEL_W];
  assign aIdx  = vAddr[OFF_W+IDX_W-1:OFF_W];
  assign aTag  = vAddr[ADDR_W-1:OFF_W+IDX_W];

  // arrays
  logic [DATA_W-1:0]    dataMem [WORDS];
  logic [TAG_W-1:0]     tagMem  [NUM_LINES];
  logic [NUM_LINES-1:0] lineValid;

  logic [TAG_W-1:0] missTag;
  logic [IDX_W-1:0] missIdx;

  // speculative read: no tag involvement
  logic [DATA_W-1:0] rawWord;
  logic [DATA_W-1:0] alignedWord;

  assign rawWord = dataMem[{aIdx, aWord}];

  slp_aligner #(.DATA_W(DATA_W)) u_align (
    .wordIn  (rawWord),
    .byteSel (aByte),
    .sizeCode(reqSize),
    .dataOut (alignedWord)
  );

  always_ff @(posedge clk) begin
    if (ctrl.fillWrite) dataMem[{missIdx, fillBeat}] <= fillData;
  end

  always_ff @(posedge clk) begin
    if (ctrl.tagWrite) tagMem[missIdx] <= missTag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineValid <= '0;
    else if (ctrl.tagWrite) lineValid[missIdx] <= 1'b1;
  end

  // stage 1: forwarded data, pending check
  logic             s1Valid;
  logic [TAG_W-1:0] s1Tag;
  logic [IDX_W-1:0] s1Idx;
  logic [DATA_W-1:0] s1Data;
  logic             s1Hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Tag   <= '0;
      s1Idx   <= '0;
      s1Data  <= '0;
    end else begin
      s1Valid <= ctrl.accept;
      if (ctrl.accept) begin
        s1Tag  <= aTag;
        s1Idx  <= aIdx;
        s1Data <= alignedWord;
      end
    end
  end

  // late tag check
  assign s1Hit  = lineValid[s1Idx] && (tagMem[s1Idx] == s1Tag);
  assign s1Miss = s1Valid && !s1Hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      checkValid <= 1'b0;
      checkHit   <= 1'b0;
    end else begin
      checkValid <= s1Valid;
      checkHit   <= s1Valid && s1Hit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missTag <= '0;
      missIdx <= '0;
    end else if (ctrl.captureMiss) begin
      missTag <= s1Tag;
      missIdx <= s1Idx;
    end
  end

  assign loadValid    = s1Valid;
  assign loadData     = s1Data;
  assign missLineAddr = {missTag, missIdx, {OFF_W{1'b0}}};
endmodule

// File: rtl/slp_control.sv
module slp_control
  import slp_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int BEATS     = LINE_BYTES / (DATA_W/8),
  localparam int BEAT_W    = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              s1Miss,
  input  logic              memReqReady,
  input  logic              memRspValid,
  output logic              reqReady,
  output slp_ctrl_t         ctrl,
  output logic [BEAT_W-1:0] fillBeat,
  output logic              memReqValid,
  output logic              memRspReady,
  output logic              restart
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  slp_state_e state, stateNext;
  logic [BEAT_W-1:0] beatNext;
  logic beatTake;

  assign beatTake    = (state == ST_FILL) && memRspValid;
  assign reqReady    = (state == ST_IDLE) && !s1Miss;
  assign memReqValid = (state == ST_REQ);
  assign memRspReady = (state == ST_FILL);
  assign restart     = (state == ST_DONE);

  always_comb begin
    ctrl.accept      = reqValid && reqReady;
    ctrl.captureMiss = (state == ST_IDLE) && s1Miss;
    ctrl.fillWrite   = beatTake;
    ctrl.tagWrite    = beatTake && (fillBeat == LAST_BEAT);
  end

  always_comb begin
    stateNext = state;
    beatNext  = fillBeat;
    case (state)
      ST_IDLE: if (s1Miss) stateNext = ST_REQ;
      ST_REQ: if (memReqReady) begin
        stateNext = ST_FILL;
        beatNext  = '0;
      end
      ST_FILL: if (memRspValid) begin
        beatNext = fillBeat + 1'b1;
        if (fillBeat == LAST_BEAT) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fillBeat <= '0;
    end else begin
      state    <= stateNext;
      fillBeat <= beatNext;
    end
  end
endmodule

// File: rtl/spec_load_path.sv
module spec_load_path
  import slp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [1:0]        reqSize,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData,
  output logic              checkValid,
  output logic              checkHit,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  output logic              memRspReady,
  input  logic [DATA_W-1:0] memRspData,
  output logic              restart
);
  localparam int BEATS  = LINE_BYTES / (DATA_W/8);
  localparam int BEAT_W = $clog2(BEATS);

  slp_ctrl_t         ctrl;
  logic [BEAT_W-1:0] fillBeat;
  logic              s1Miss;

  slp_control #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .s1Miss     (s1Miss),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .reqReady   (reqReady),
    .ctrl       (ctrl),
    .fillBeat   (fillBeat),
    .memReqValid(memReqValid),
    .memRspReady(memRspReady),
    .restart    (restart)
  );

  slp_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .fillBeat    (fillBeat),
    .reqBase     (reqBase),
    .reqOffset   (reqOffset),
    .reqSize     (reqSize),
    .fillData    (memRspData),
    .loadValid   (loadValid),
    .loadData    (loadData),
    .checkValid  (checkValid),
    .checkHit    (checkHit),
    .s1Miss      (s1Miss),
    .missLineAddr(memReqAddr)
  );
endmodule

// File: rtl/slp_checker.sv
module slp_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              loadValid,
  input logic              checkValid,
  input logic              checkHit,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              memRspReady,
  input logic              restart
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int BEATS = LINE_BYTES / (DATA_W/8);
  localparam int CNT_W = $clog2(BEATS) + 2;

  logic [CNT_W-1:0] beatsSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) beatsSeen <= '0;
    else if (memReqValid && memReqReady) beatsSeen <= '0;
    else if (memRspValid && memRspReady) beatsSeen <= beatsSeen + 1'b1;
  end

  assert_load_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> loadValid);

  assert_verdict_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> checkValid);

  assert_miss_requests_R6: assert property (@(posedge clk) disable iff (!rstN)
    (checkValid && !checkHit) |-> memReqValid);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  assert_req_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[OFF_W-1:0] == '0));

  assert_full_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    restart |-> (beatsSeen == CNT_W'(BEATS)));

  assert_restart_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !restart);

  assert_blocked_refill_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || memRspReady || restart) |-> !reqReady);

  assert_verdict_no_fetch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (checkValid && checkHit) |-> !memReqValid);
endmodule

bind spec_load_path slp_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
) u_slp_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .loadValid  (loadValid),
  .checkValid (checkValid),
  .checkHit   (checkHit),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .memRspValid(memRspValid),
  .memRspReady(memRspReady),
  .restart    (restart)
);

// File: tb/test_spec_load_path.sv
module test_spec_load_path;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqBase = '0;
  logic [31:0] reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic        loadValid;
  logic [31:0] loadData;
  logic        checkValid;
  logic        checkHit;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic        memRspReady;
  logic [31:0] memRspData = '0;
  logic        restart;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic        refValid [128];
  logic [19:0] refTag   [128];

  spec_load_path i_spec_load_path (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqSize(reqSize),
    .loadValid(loadValid), .loadData(loadData),
    .checkValid(checkValid), .checkHit(checkHit),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspReady(memRspReady), .memRspData(memRspData),
    .restart(restart)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ {a[15:0], a[31:16]} ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [31:0] alignExp(input logic [31:0] w, input logic [1:0] b, input logic [1:0] sz);
    logic [31:0] s;
    s = w >> (8 * b);
    case (sz)
      2'd0:    return s & 32'h0000_00FF;
      2'd1:    return s & 32'h0000_FFFF;
      default: return s;
    endcase
  endfunction

  task automatic refill(input logic [31:0] addr);
    logic [31:0] line;
    line = {addr[31:5], 5'b0};
    chk(memReqValid == 1'b1, "R6 request raised", {31'b0, memReqValid}, 32'd1);
    chk(memReqAddr == line, "R6 line address", memReqAddr, line);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(memReqValid == 1'b1 && memReqAddr == line, "R6 request held", memReqAddr, line);
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    chk(memReqValid == 1'b0, "R6 request dropped", {31'b0, memReqValid}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      repeat ($urandom % 3) @(negedge clk);
      memRspValid = 1'b1;
      memRspData  = memWord(line + 32'(4 * k));
      chk(memRspReady == 1'b1, "R7 beat ready", {31'b0, memRspReady}, 32'd1);
      @(negedge clk);
      memRspValid = 1'b0;
    end
    chk(restart == 1'b1, "R8 restart pulse", {31'b0, restart}, 32'd1);
    chk(reqReady == 1'b0, "R9 blocked in restart", {31'b0, reqReady}, 32'd0);
    @(negedge clk);
    chk(restart == 1'b0, "R8 single pulse", {31'b0, restart}, 32'd0);
    chk(reqReady == 1'b1, "R9 ready again", {31'b0, reqReady}, 32'd1);
    refValid[addr[11:5]] = 1'b1;
    refTag[addr[11:5]]   = addr[31:12];
  endtask

  // returns whether the load hit
  task automatic doLoad(input logic [31:0] base, input logic [31:0] off, input logic [1:0] sz,
                        input string req, output logic hit);
    logic [31:0] addr, expData;
    logic expHit;
    addr    = base + off;
    expHit  = refValid[addr[11:5]] && (refTag[addr[11:5]] == addr[31:12]);
    expData = alignExp(memWord({addr[31:2], 2'b0}), addr[1:0], sz);
    reqValid = 1'b1; reqBase = base; reqOffset = off; reqSize = sz;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(loadValid == 1'b1, "R2 data valid", {31'b0, loadValid}, 32'd1);
    if (expHit) chk(loadData == expData, req, loadData, expData);
    chk(reqReady == expHit, "R9 ready after verdict", {31'b0, reqReady}, {31'b0, expHit});
    @(negedge clk);
    chk(loadValid == 1'b0, "R2 single cycle", {31'b0, loadValid}, 32'd0);
    chk(checkValid == 1'b1 && checkHit == expHit, "R4 verdict", {30'b0, checkValid, checkHit}, {30'b0, 1'b1, expHit});
    if (!expHit) refill(addr);
    hit = expHit;
  endtask

  initial begin
    logic h;
    logic [31:0] a, b;
    for (int i = 0; i < 128; i++) begin refValid[i] = 1'b0; refTag[i] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(reqReady == 1'b1 && loadValid == 1'b0 && checkValid == 1'b0 && memReqValid == 1'b0 && restart == 1'b0,
        "R10 in reset", {27'b0, reqReady, loadValid, checkValid, memReqValid, restart}, 32'h10);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && loadValid == 1'b0 && memReqValid == 1'b0 && restart == 1'b0,
        "R10 after reset", {28'b0, reqReady, loadValid, memReqValid, restart}, 32'h8);

    // R5 cold miss at address 0, then all words of the line via R7
    doLoad(32'h0, 32'h0, 2'd2, "R5 data", h);
    chk(h == 1'b0, "R5 first access misses", {31'b0, h}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      doLoad(32'h0, 32'(4 * k), 2'd2, "R7 beat order data", h);
      chk(h == 1'b1, "R7 line filled", {31'b0, h}, 32'd1);
    end

    // R3 every size at every byte position
    for (int sz = 0; sz < 4; sz++)
      for (int bp = 0; bp < 4; bp++)
        doLoad(32'h10, 32'(bp), 2'(sz), "R3 aligned data", h);

    // R1 adder wrap: 0xFFFFFFF0 + 0x24 = 0x14
    doLoad(32'hFFFF_FFF0, 32'h24, 2'd2, "R1 wrapped sum data", h);
    chk(h == 1'b1, "R1 wrap hits line 0", {31'b0, h}, 32'd1);

    // R11 conflict at index 0 with another tag, then original misses again
    doLoad(32'h0012_3000, 32'h4, 2'd2, "R11 data", h);
    chk(h == 1'b0, "R11 conflict misses", {31'b0, h}, 32'd0);
    doLoad(32'h0, 32'h8, 2'd2, "R11 data", h);
    chk(h == 1'b0, "R11 evicted line misses", {31'b0, h}, 32'd0);

    // R2 R4 back-to-back hits at line 0 words 1 and 6
    a = 32'h4; b = 32'h18;
    reqValid = 1'b1; reqBase = 32'h0; reqOffset = a; reqSize = 2'd2;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    chk(reqReady == 1'b1, "R9 ready after hit", {31'b0, reqReady}, 32'd1);
    chk(loadData == memWord(a), "R2 first back-to-back data", loadData, memWord(a));
    reqOffset = b;
    @(negedge clk);
    reqValid = 1'b0;
    chk(checkValid && checkHit, "R4 first verdict", {30'b0, checkValid, checkHit}, 32'd3);
    chk(loadValid && loadData == memWord(b), "R2 second back-to-back data", loadData, memWord(b));
    @(negedge clk);
    chk(checkValid && checkHit, "R4 second verdict", {30'b0, checkValid, checkHit}, 32'd3);

    // constrained random mix: two tags, six indices, random operands
    for (int n = 0; n < 250; n++) begin
      logic [31:0] addr, base;
      addr = {(($urandom % 2) == 0) ? 20'h00ABC : 20'h7F012, 7'($urandom % 6), 5'($urandom)};
      base = $urandom;
      doLoad(base, addr - base, 2'($urandom), "R3 random load data", h);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule